// File: doc/BRIEF.md
# Boot-Overlay Bus Address Decoder

This block turns the 20-bit address of a CPU with an 8-bit data bus and an asynchronous bus handshake into active-low chip selects. The 1 MB space has five regions: static RAM in the lower half, flash in the next quarter, a 128 kB peripheral window that acknowledges itself, a 64 kB window whose devices return their own acknowledge, and a 64 kB window served by the legacy synchronous transfer protocol. The peripheral window is split further into three 32 kB selects and four 8 kB selects.

The CPU fetches its initial stack pointer and reset vector from address zero, but RAM should sit at address zero during normal operation so that the exception vectors can be changed. A boot flag cleared by the CPU reset therefore overlays a boot device on the whole RAM range. The boot-select input chooses that device: flash, or an alternate device in the externally acknowledged window. The first access to one designated peripheral select sets the flag, and from then on RAM is visible until the next reset.

Top module: `bootMapDecoder`

## Requirements
- R1: While the address strobe `asN` is high, every chip select, `dtackN` and `vpaN` are high.
- R2: With the boot flag set, a strobed address in 0x00000–0x7FFFF drives `ramCsN` low and `dtackN` low in the same cycle.
- R3: A strobed address in 0x80000–0xBFFFF drives `flashCsN` low and `dtackN` low.
- R4: A strobed address in 0xC0000–0xDFFFF drives `dtackN` low and exactly one bit of `subCsN` low: bit 0 for 0xC0000–0xC7FFF, bit 1 for 0xC8000–0xCFFFF, bit 2 for 0xD0000–0xD7FFF, and bits 3, 4, 5, 6 for the 8 kB blocks at 0xD8000, 0xDA000, 0xDC000, 0xDE000.
- R5: A strobed address in 0xE0000–0xEFFFF drives `extCsN` low, and `dtackN` equals `extAckN`.
- R6: A strobed address in 0xF0000–0xFFFFF drives `syncCsN` low and `vpaN` low, and keeps `dtackN` high.
- R7: Reset (`rstN` low) clears the boot flag. A strobed access to `subCsN` bit 0 sets it at the next rising clock edge. No other access sets it, and it stays set until the next reset. The flag is seen through R2, R8 and R9.
- R8: With the boot flag clear and `bootSel` = 0, a strobed address in 0x00000–0x7FFFF selects flash (`flashCsN` low, `dtackN` low) and leaves `ramCsN` high.
- R9: With the boot flag clear and `bootSel` = 1, a strobed address in 0x00000–0x7FFFF selects `extCsN`, `dtackN` follows `extAckN`, and `ramCsN` stays high.
- R10: At most one of the chip selects (`ramCsN`, `flashCsN`, `subCsN`, `extCsN`, `syncCsN`) is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boot flag |
| rstN | input | 1 | Active-low asynchronous reset, shared with the CPU |
| addr | input | 20 | CPU address bus |
| asN | input | 1 | Active-low address strobe |
| bootSel | input | 1 | Boot device choice while the flag is clear (0 flash, 1 alternate) |
| extAckN | input | 1 | Active-low acknowledge from externally acknowledged devices |
| ramCsN | output | 1 | RAM select |
| flashCsN | output | 1 | Flash select |
| subCsN | output | 7 | Peripheral window sub-selects |
| extCsN | output | 1 | Externally acknowledged window select |
| syncCsN | output | 1 | Synchronous legacy window select |
| dtackN | output | 1 | Data-transfer acknowledge to the CPU |
| vpaN | output | 1 | Valid-peripheral-address request for a synchronous transfer |

## Verification
The hardest case to reach is the alternate boot overlay after the flag has nearly been set. The overlay appears only between a reset and the first access to the designated sub-block, so the stimulus resets with `bootSel` high, fetches low addresses with `extAckN` held both ways, and then accesses a different sub-block and an unstrobed address on the designated block. The overlay must still be visible after those accesses, and only a strobed access to the designated block may switch low memory to RAM. A second reset must bring the overlay back.

// File: rtl/bootMapDecoderPkg.sv
package bootMapDecoderPkg;

  // Strobes from the boot control to the decode datapath
  typedef struct packed {
    logic overlayOn;  // boot flag clear: low half shows the boot device
    logic altBoot;    // alternate device instead of flash
  } bootStrobe_t;

  typedef enum logic [2:0] {
    REG_RAM,
    REG_FLASH,
    REG_PERIPH,
    REG_EXT,
    REG_SYNC
  } region_t;

endpackage

// File: rtl/bootMapCtrl.sv
module bootMapCtrl
  import bootMapDecoderPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bootSel,
  input  logic        doneHit,
  output bootStrobe_t strobe
);

  logic bootDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        bootDone <= 1'b0;
    else if (doneHit) bootDone <= 1'b1;
  end

  always_comb begin
    strobe.overlayOn = !bootDone;
    strobe.altBoot   = bootSel;
  end

  // R7: the flag never clears without a reset
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> bootDone);

  // R7: an access to the designated block sets the flag
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    doneHit |=> bootDone);

endmodule

// File: rtl/bootMapDatapath.sv
module bootMapDatapath
  import bootMapDecoderPkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_BIG   = 3,
  parameter int NUM_SMALL = 4,
  parameter int DONE_IDX  = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          asN,
  input  logic                          extAckN,
  input  bootStrobe_t                   strobe,
  output logic                          ramCsN,
  output logic                          flashCsN,
  output logic [NUM_BIG+NUM_SMALL-1:0]  subCsN,
  output logic                          extCsN,
  output logic                          syncCsN,
  output logic                          dtackN,
  output logic                          vpaN,
  output logic                          doneHit
);

  localparam int NUM_SUB = NUM_BIG + NUM_SMALL;
  // Peripheral window is one eighth of the space; it is cut in quarters,
  // and the last quarter is cut again in quarters.
  localparam int BIG_LSB   = ADDR_W - 5;
  localparam int SMALL_LSB = ADDR_W - 7;
  localparam logic [1:0] SPLIT_SLOT = 2'(NUM_BIG);

  region_t    rawRegion;
  region_t    region;
  logic       sel;
  logic [1:0] bigIdx;
  logic [1:0] smallIdx;
  logic [NUM_SUB-1:0] subHit;

  assign sel      = !asN;
  assign bigIdx   = addr[BIG_LSB+1:BIG_LSB];
  assign smallIdx = addr[SMALL_LSB+1:SMALL_LSB];

  // Region by leading address bits
  always_comb begin
    if (!addr[ADDR_W-1])      rawRegion = REG_RAM;
    else if (!addr[ADDR_W-2]) rawRegion = REG_FLASH;
    else if (!addr[ADDR_W-3]) rawRegion = REG_PERIPH;
    else if (!addr[ADDR_W-4]) rawRegion = REG_EXT;
    else                      rawRegion = REG_SYNC;
  end

  // Boot overlay replaces the whole low half
  always_comb begin
    region = rawRegion;
    if (rawRegion == REG_RAM && strobe.overlayOn)
      region = strobe.altBoot ? REG_EXT : REG_FLASH;
  end

  generate
    for (genvar g = 0; g < NUM_BIG; g++) begin : gBig
      assign subHit[g] = (bigIdx == 2'(g));
    end
    for (genvar g = 0; g < NUM_SMALL; g++) begin : gSmall
      assign subHit[NUM_BIG+g] = (bigIdx == SPLIT_SLOT) && (smallIdx == 2'(g));
    end
    for (genvar g = 0; g < NUM_SUB; g++) begin : gSubCs
      assign subCsN[g] = !(sel && region == REG_PERIPH && subHit[g]);
    end
  endgenerate

  assign ramCsN   = !(sel && region == REG_RAM);
  assign flashCsN = !(sel && region == REG_FLASH);
  assign extCsN   = !(sel && region == REG_EXT);
  assign syncCsN  = !(sel && region == REG_SYNC);
  assign vpaN     = !(sel && region == REG_SYNC);
  assign doneHit  = !subCsN[DONE_IDX];

  always_comb begin
    dtackN = 1'b1;
    if (sel) begin
      unique case (region)
        REG_RAM, REG_FLASH, REG_PERIPH: dtackN = 1'b0;
        REG_EXT:                        dtackN = extAckN;
        default:                        dtackN = 1'b1;
      endcase
    end
  end

  // R1: no strobe, nothing driven
  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> (ramCsN && flashCsN && (&subCsN) && extCsN && syncCsN && dtackN && vpaN));

  // R10: chip selects are mutually exclusive
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~{ramCsN, flashCsN, subCsN, extCsN, syncCsN}));

  // R2: RAM only visible once the overlay is gone
  a_r2_ram_after_boot: assert property (@(posedge clk) disable iff (!rstN)
    !ramCsN |-> (!strobe.overlayOn && !dtackN));

  // R5: external window passes the device acknowledge
  a_r5_ext_ack: assert property (@(posedge clk) disable iff (!rstN)
    !extCsN |-> (dtackN == extAckN));

  // R6: synchronous window requests a legacy cycle, no async acknowledge
  a_r6_sync_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !syncCsN |-> (!vpaN && dtackN));

endmodule

// File: rtl/bootMapDecoder.sv
module bootMapDecoder
  import bootMapDecoderPkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_BIG   = 3,
  parameter int NUM_SMALL = 4,
  parameter int DONE_IDX  = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         asN,
  input  logic                         bootSel,
  input  logic                         extAckN,
  output logic                         ramCsN,
  output logic                         flashCsN,
  output logic [NUM_BIG+NUM_SMALL-1:0] subCsN,
  output logic                         extCsN,
  output logic                         syncCsN,
  output logic                         dtackN,
  output logic                         vpaN
);

  bootStrobe_t strobe;
  logic        doneHit;

  bootMapCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bootSel (bootSel),
    .doneHit (doneHit),
    .strobe  (strobe)
  );

  bootMapDatapath #(
    .ADDR_W    (ADDR_W),
    .NUM_BIG   (NUM_BIG),
    .NUM_SMALL (NUM_SMALL),
    .DONE_IDX  (DONE_IDX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .asN      (asN),
    .extAckN  (extAckN),
    .strobe   (strobe),
    .ramCsN   (ramCsN),
    .flashCsN (flashCsN),
    .subCsN   (subCsN),
    .extCsN   (extCsN),
    .syncCsN  (syncCsN),
    .dtackN   (dtackN),
    .vpaN     (vpaN),
    .doneHit  (doneHit)
  );

endmodule

// File: tb/bootMapDecoder_tb.sv
module bootMapDecoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addr = '0;
  logic        asN = 1'b1;
  logic        bootSel = 1'b0;
  logic        extAckN = 1'b1;
  logic        ramCsN, flashCsN, extCsN, syncCsN, dtackN, vpaN;
  logic [6:0]  subCsN;

  always #10 clk = !clk;

  bootMapDecoder u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .bootSel(bootSel),
    .extAckN(extAckN), .ramCsN(ramCsN), .flashCsN(flashCsN), .subCsN(subCsN),
    .extCsN(extCsN), .syncCsN(syncCsN), .dtackN(dtackN), .vpaN(vpaN)
  );

  typedef struct {
    logic [12:0] vec;   // {ram, flash, sub[6:0], ext, sync, dtack, vpa}
    string       tag;
  } item_t;

  item_t expQ[$];
  int    nCompared = 0;
  int    nFailed   = 0;
  logic  flagModel = 1'b0;
  bit    doneFlag  = 1'b0;

  function automatic logic [12:0] model(logic [19:0] a, logic as_n, logic bs,
                                        logic ack, logic flag);
    logic ram, fl, ext, syn, dt, vp;
    logic [6:0] sub;
    int off;
    ram = 1; fl = 1; ext = 1; syn = 1; dt = 1; vp = 1; sub = '1;
    if (!as_n) begin
      if (a < 20'h80000) begin
        if (flag)    begin ram = 0; dt = 0; end
        else if (bs) begin ext = 0; dt = ack; end
        else         begin fl = 0; dt = 0; end
      end else if (a < 20'hC0000) begin
        fl = 0; dt = 0;
      end else if (a < 20'hE0000) begin
        off = int'(a) - 'hC0000;
        if (off < 'h18000) sub[off / 'h8000] = 0;
        else               sub[3 + (off - 'h18000) / 'h2000] = 0;
        dt = 0;
      end else if (a < 20'hF0000) begin
        ext = 0; dt = ack;
      end else begin
        syn = 0; vp = 0;
      end
    end
    return {ram, fl, sub, ext, syn, dt, vp};
  endfunction

  task automatic apply(logic [19:0] a, logic as_n, logic bs, logic ack, string tag);
    item_t it;
    @(negedge clk);
    addr = a; asN = as_n; bootSel = bs; extAckN = ack;
    it.vec = model(a, as_n, bs, ack, flagModel);
    it.tag = tag;
    expQ.push_back(it);
    if (!as_n && a >= 20'hC0000 && a < 20'hC8000) flagModel = 1'b1;
  endtask

  task automatic doReset(string tag);
    item_t it;
    @(negedge clk);
    rstN = 1'b0; asN = 1'b1; flagModel = 1'b0;
    it.vec = model(addr, 1'b1, bootSel, extAckN, 1'b0);
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Monitor: compares mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() > 0) begin
        item_t it;
        logic [12:0] act;
        it  = expQ.pop_front();
        act = {ramCsN, flashCsN, subCsN, extCsN, syncCsN, dtackN, vpaN};
        nCompared++;
        if (act !== it.vec) begin
          nFailed++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.vec);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!doneFlag) begin
      nFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  end

  initial begin
    doReset("R1 R7 reset state");
    apply(20'h00000, 1, 0, 1, "R1 idle at zero");
    // flash overlay boot fetch
    for (int i = 0; i < 8; i++) apply(20'(i), 0, 0, 1, "R8 boot fetch from flash");
    apply(20'h7FFFF, 0, 0, 1, "R8 overlay top of low half");
    apply(20'hC8000, 0, 0, 1, "R7 other block does not set flag");
    apply(20'hC0000, 1, 0, 1, "R7 unstrobed designated block");
    apply(20'h00004, 0, 0, 1, "R7 R8 overlay still present");
    // alternate boot device
    apply(20'h00000, 0, 1, 0, "R9 alt boot acked");
    apply(20'h00002, 0, 1, 1, "R9 alt boot waiting");
    apply(20'h40000, 0, 1, 0, "R9 alt boot mid range");
    // regions unaffected by flag
    apply(20'h80000, 0, 0, 1, "R3 flash base");
    apply(20'hBFFFF, 0, 1, 1, "R3 flash top");
    apply(20'hE0000, 0, 0, 0, "R5 ext acked");
    apply(20'hEFFFF, 0, 0, 1, "R5 ext waiting");
    apply(20'hF0000, 0, 0, 0, "R6 sync base");
    apply(20'hFFFFF, 0, 0, 1, "R6 sync top");
    // sub-blocks, base and top of each (R10 exclusivity in every vector)
    apply(20'hC7FFF, 0, 0, 1, "R4 block0 top");
    apply(20'hCFFFF, 0, 0, 1, "R4 block1 top");
    apply(20'hD0000, 0, 0, 1, "R4 block2 base");
    apply(20'hD7FFF, 0, 0, 1, "R4 block2 top");
    apply(20'hD8000, 0, 0, 1, "R4 block3 base");
    apply(20'hD9FFF, 0, 0, 1, "R4 block3 top");
    apply(20'hDA000, 0, 0, 1, "R4 block4 base");
    apply(20'hDC000, 0, 0, 1, "R4 block5 base");
    apply(20'hDE000, 0, 0, 1, "R4 block6 base");
    apply(20'hDFFFF, 0, 0, 1, "R4 R10 block6 top");
    apply(20'h00000, 0, 0, 1, "R2 RAM at zero after boot");
    apply(20'h7FFFF, 0, 1, 0, "R2 R7 RAM top, bootSel ignored");
    apply(20'h12345, 0, 1, 1, "R2 RAM mid");
    apply(20'hC0000, 1, 0, 0, "R1 idle with peripheral address");
    apply(20'hF1234, 1, 0, 0, "R1 idle with sync address");
    doReset("R7 second reset");
    apply(20'h00000, 0, 1, 1, "R7 R9 overlay back after reset");
    apply(20'h00000, 0, 0, 1, "R7 R8 overlay back after reset");
    apply(20'hC3000, 0, 0, 1, "R4 R7 designated block mid");
    apply(20'h00008, 0, 0, 1, "R2 R7 RAM after second set");
    repeat (3) @(negedge clk);
    doneFlag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
    $finish;
  end

endmodule